// File: doc/BRIEF.md
# Receive Gain Distribution Controller

This block turns one receive gain setting into the individual codes of a receive chain. The chain has five coarse stages: the low-noise amplifier, the mixer and three baseband amplifiers. All five share a 6 dB step. After them comes a fine trim stage with steps of about 0.76 dB. The gain setting arrives as a short serial word on a dedicated three-wire port, made of an active-low frame enable, a serial clock and a data line. The port is sampled through synchronisers in the block's own clock domain.

The block spends the coarse part of the word on the front of the chain first. The low-noise amplifier fills to its top step, then the mixer, then the baseband amplifiers in order. When the gain is lowered, the later stages give up their steps first. Each stage whose code changes gets a one-cycle request to its own DC offset correction loop.

A separately loaded output offset code sets the drive level of the output buffer. It is independent of the gain word.

Top module: `rxg_gain_dist`

## Requirements
- R1: While reset is held and just after it is released, every coarse code and the fine code are 0, the offset code is 2 (about 0 dB) and no correction request is raised.
- R2: Let C be the coarse count. Coarse stage k is numbered 0 for the low-noise amplifier, 1 for the mixer, and 2, 3, 4 for baseband amplifiers one to three. Its 2-bit code is 0 when C ≤ 3k, 3 when C ≥ 3k+3, and C−3k otherwise. A stage therefore never holds a nonzero code unless the stage before it is at 3.
- R3: A coarse code n selects n steps of 6 dB: 0/6/12/18 dB for the low-noise and baseband amplifiers and 4/10/16/22 dB for the mixer. The fine code equals the three fine bits of the word.
- R4: The serial word is 7 bits long and sent MSB first. Each bit is sampled on a rising serial clock edge while the enable is low. Bits 6..3 form the coarse count (0 to 15) and bits 2..0 form the fine code.
- R5: A word takes effect only when the enable returns high after exactly 7 clock edges. Frames of 6 or 8 bits leave every code unchanged and raise no request.
- R6: `dcoc_req` has one bit per stage. Bit 0 is the low-noise amplifier, bit 1 the mixer, bits 2 to 4 are baseband amplifiers one to three, and bit 5 is the fine stage. A bit pulses for exactly one cycle, in the same cycle the stage's new code appears, and only if that code differs from the previous one. Rewriting an identical word raises no request.
- R7: A high `ofs_load` stores `ofs_val` as the offset code, clamped to 10. Code n stands for −1.5 dB + n × 0.76 dB.
- R8: Offset loads change no gain code and raise no request, and gain words do not change the offset code. When a word commit and an offset load fall in the same cycle, both take effect.
- R9: A coarse count of 15 sets all five coarse stages to 3, and a count of 0 sets all of them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gs_en_n | input | 1 | Serial frame enable, active low |
| gs_clk | input | 1 | Serial bit clock, data sampled on its rising edge |
| gs_dat | input | 1 | Serial data, MSB first |
| ofs_load | input | 1 | Store `ofs_val` as the offset code |
| ofs_val | input | 4 | New output offset code |
| lna_code | output | 2 | Low-noise amplifier step code |
| mix_code | output | 2 | Mixer step code |
| bb_code | output | 6 | Baseband amplifier codes, amplifier one in bits 1:0 |
| fine_code | output | 3 | Fine trim code |
| ofs_code | output | 4 | Output offset code |
| dcoc_req | output | 6 | Per-stage offset correction request pulses |

## Verification
A gain word commit and an offset load can land in the same clock cycle. The bench forces this by holding `ofs_load` high across the whole end of a frame, so the internal commit must fall inside the load window. It then judges that the new stage codes and the new offset code both appear. The request pulses must match exactly the stages whose codes moved, and the offset change must add no request of its own.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    localparam int STEP_W   = 2;
    localparam int STEP_MAX = 3;

    // share of a coarse count that lands on stage idx when stages fill in order
    function automatic logic [STEP_W-1:0] stage_share(input int unsigned level,
                                                      input int unsigned idx);
        int unsigned base;
        base = idx * STEP_MAX;
        if (level <= base) begin
            return '0;
        end else if (level - base >= STEP_MAX) begin
            return STEP_W'(STEP_MAX);
        end else begin
            return STEP_W'(level - base);
        end
    endfunction

endpackage

// File: rtl/rxg_ser_rx.sv
module rxg_ser_rx #(
    parameter int WORD_W   = 7,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_TOP = WORD_W + 1;

    typedef struct packed {
        logic [SYNC_LEN-1:0] en_sy;
        logic [SYNC_LEN-1:0] ck_sy;
        logic [SYNC_LEN-1:0] dt_sy;
        logic                en_p;
        logic                ck_p;
        logic [WORD_W-1:0]   sh;
        logic [CNT_W-1:0]    cnt;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic en_s, ck_s, dt_s, ck_rise, en_rise;

    always_comb begin
        en_s    = st_q.en_sy[SYNC_LEN-1];
        ck_s    = st_q.ck_sy[SYNC_LEN-1];
        dt_s    = st_q.dt_sy[SYNC_LEN-1];
        ck_rise = ck_s & ~st_q.ck_p;
        en_rise = en_s & ~st_q.en_p;

        st_d       = st_q;
        st_d.en_sy = {st_q.en_sy[SYNC_LEN-2:0], en_n};
        st_d.ck_sy = {st_q.ck_sy[SYNC_LEN-2:0], sck};
        st_d.dt_sy = {st_q.dt_sy[SYNC_LEN-2:0], sdi};
        st_d.en_p  = en_s;
        st_d.ck_p  = ck_s;

        if (en_s) begin
            st_d.cnt = '0;
        end else if (ck_rise) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], dt_s};
            if (st_q.cnt != CNT_W'(CNT_TOP)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        word_vld = en_rise && (st_q.cnt == CNT_W'(WORD_W));
        word     = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.en_sy <= '1;
            st_q.en_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxg_split.sv
module rxg_split
    import rxg_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int N_COARSE = 5
) (
    input  logic [COARSE_W-1:0]                coarse,
    output logic [N_COARSE-1:0][STEP_W-1:0]    codes
);

    for (genvar g = 0; g < N_COARSE; g++) begin : g_stage
        assign codes[g] = stage_share(int'(coarse), g);
    end

endmodule

// File: rtl/rxg_gain_dist.sv
module rxg_gain_dist
    import rxg_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 3,
    parameter int N_BB     = 3,
    parameter int OFS_W    = 4,
    parameter int OFS_MAX  = 10,
    parameter int OFS_RST  = 2,
    parameter int SYNC_LEN = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gs_en_n,
    input  logic                   gs_clk,
    input  logic                   gs_dat,
    input  logic                   ofs_load,
    input  logic [OFS_W-1:0]       ofs_val,
    output logic [STEP_W-1:0]      lna_code,
    output logic [STEP_W-1:0]      mix_code,
    output logic [N_BB*STEP_W-1:0] bb_code,
    output logic [FINE_W-1:0]      fine_code,
    output logic [OFS_W-1:0]       ofs_code,
    output logic [N_BB+2:0]        dcoc_req
);

    localparam int N_COARSE = N_BB + 2;
    localparam int N_REQ    = N_COARSE + 1;
    localparam int WORD_W   = COARSE_W + FINE_W;

    typedef struct packed {
        logic [N_COARSE-1:0][STEP_W-1:0] crs;
        logic [FINE_W-1:0]               fine;
        logic [OFS_W-1:0]                ofs;
        logic [N_REQ-1:0]                req;
    } gd_st_t;

    gd_st_t st_d, st_q;

    logic                            word_vld;
    logic [WORD_W-1:0]               word;
    logic [N_COARSE-1:0][STEP_W-1:0] split_codes;

    rxg_ser_rx #(
        .WORD_W   (WORD_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (gs_en_n),
        .sck      (gs_clk),
        .sdi      (gs_dat),
        .word_vld (word_vld),
        .word     (word)
    );

    rxg_split #(
        .COARSE_W (COARSE_W),
        .N_COARSE (N_COARSE)
    ) u_split (
        .coarse (word[WORD_W-1:FINE_W]),
        .codes  (split_codes)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = '0;
        if (word_vld) begin
            st_d.crs  = split_codes;
            st_d.fine = word[FINE_W-1:0];
            for (int i = 0; i < N_COARSE; i++) begin
                st_d.req[i] = (split_codes[i] != st_q.crs[i]);
            end
            st_d.req[N_COARSE] = (word[FINE_W-1:0] != st_q.fine);
        end
        if (ofs_load) begin
            st_d.ofs = (ofs_val > OFS_W'(OFS_MAX)) ? OFS_W'(OFS_MAX) : ofs_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ofs <= OFS_W'(OFS_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign lna_code  = st_q.crs[0];
    assign mix_code  = st_q.crs[1];
    assign bb_code   = st_q.crs[N_COARSE-1:2];
    assign fine_code = st_q.fine;
    assign ofs_code  = st_q.ofs;
    assign dcoc_req  = st_q.req;

endmodule

// File: rtl/rxg_gain_dist_chk.sv
module rxg_gain_dist_chk #(
    parameter int FINE_W  = 3,
    parameter int N_BB    = 3,
    parameter int OFS_W   = 4,
    parameter int OFS_MAX = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           lna_code,
    input logic [1:0]           mix_code,
    input logic [N_BB*2-1:0]    bb_code,
    input logic [FINE_W-1:0]    fine_code,
    input logic [OFS_W-1:0]     ofs_code,
    input logic [N_BB+2:0]      dcoc_req
);

    localparam int N_COARSE = N_BB + 2;

    logic [N_COARSE*2-1:0] all_c;
    assign all_c = {bb_code, mix_code, lna_code};

    for (genvar g = 0; g < N_COARSE; g++) begin : g_req
        // R6
        stage_req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dcoc_req[g] == (all_c[2*g +: 2] != $past(all_c[2*g +: 2])));
    end

    for (genvar g = 1; g < N_COARSE; g++) begin : g_order
        // R2
        fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (all_c[2*g +: 2] != 2'd0) |-> (all_c[2*(g-1) +: 2] == 2'd3));
    end

    // R6
    fine_req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcoc_req[N_COARSE] == (fine_code != $past(fine_code)));

    // R6
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcoc_req != '0) |=> (dcoc_req == '0));

    // R7
    ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_code <= OFS_W'(OFS_MAX));

endmodule

bind rxg_gain_dist rxg_gain_dist_chk #(
    .FINE_W  (FINE_W),
    .N_BB    (N_BB),
    .OFS_W   (OFS_W),
    .OFS_MAX (OFS_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lna_code  (lna_code),
    .mix_code  (mix_code),
    .bb_code   (bb_code),
    .fine_code (fine_code),
    .ofs_code  (ofs_code),
    .dcoc_req  (dcoc_req)
);

// File: tb/rxg_gain_dist_bench.sv
module rxg_gain_dist_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gs_en_n = 1'b1;
    logic       gs_clk = 1'b0;
    logic       gs_dat = 1'b0;
    logic       ofs_load = 1'b0;
    logic [3:0] ofs_val = 4'd0;
    logic [1:0] lna_code, mix_code;
    logic [5:0] bb_code;
    logic [2:0] fine_code;
    logic [3:0] ofs_code;
    logic [5:0] dcoc_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int hi_cnt [6];
    int rise_cnt [6];
    logic [5:0] req_prev = '0;

    int exp_c [6];   // 0..4 coarse stages, 5 fine
    int exp_ofs;
    int snap_hi [6];
    int snap_rise [6];
    int exp_pulse [6];

    always #2.5 clk = ~clk;

    rxg_gain_dist u_rxg_gain_dist (
        .clk       (clk),
        .rst_n     (rst_n),
        .gs_en_n   (gs_en_n),
        .gs_clk    (gs_clk),
        .gs_dat    (gs_dat),
        .ofs_load  (ofs_load),
        .ofs_val   (ofs_val),
        .lna_code  (lna_code),
        .mix_code  (mix_code),
        .bb_code   (bb_code),
        .fine_code (fine_code),
        .ofs_code  (ofs_code),
        .dcoc_req  (dcoc_req)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (dcoc_req[i]) hi_cnt[i] = hi_cnt[i] + 1;
            if (dcoc_req[i] && !req_prev[i]) rise_cnt[i] = rise_cnt[i] + 1;
        end
        req_prev = dcoc_req;
    end

    function automatic int act_code(input int i);
        case (i)
            0: return int'(lna_code);
            1: return int'(mix_code);
            2: return int'(bb_code[1:0]);
            3: return int'(bb_code[3:2]);
            4: return int'(bb_code[5:4]);
            default: return int'(fine_code);
        endcase
    endfunction

    function automatic int share(input int c, input int k);
        if (c >= 3*k + 3) return 3;
        if (c <= 3*k) return 0;
        return c - 3*k;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        for (int i = 0; i < 6; i++) begin
            snap_hi[i] = hi_cnt[i];
            snap_rise[i] = rise_cnt[i];
            exp_pulse[i] = 0;
        end
    endtask

    // new expected word; marks expected pulses for changed stages
    task automatic expect_word(input int c, input int f);
        for (int k = 0; k < 5; k++) begin
            if (share(c, k) != exp_c[k]) exp_pulse[k] = 1;
            exp_c[k] = share(c, k);
        end
        if (f != exp_c[5]) exp_pulse[5] = 1;
        exp_c[5] = f;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 6; i++) begin
            chk(act_code(i) == exp_c[i], {tag, " code"}, act_code(i), exp_c[i]);
            chk(hi_cnt[i] - snap_hi[i] == exp_pulse[i], {tag, " R6 pulse cycles"},
                hi_cnt[i] - snap_hi[i], exp_pulse[i]);
            chk(rise_cnt[i] - snap_rise[i] == exp_pulse[i], {tag, " R6 pulse count"},
                rise_cnt[i] - snap_rise[i], exp_pulse[i]);
        end
        chk(int'(ofs_code) == exp_ofs, {tag, " offset"}, int'(ofs_code), exp_ofs);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n bits of v, MSB first
    task automatic send_bits(input int v, input int n, input bit hold_tail);
        gs_en_n = 1'b0;
        wait_clk(4);
        for (int b = n - 1; b >= 0; b--) begin
            gs_dat = v[b];
            gs_clk = 1'b0;
            wait_clk(4);
            gs_clk = 1'b1;
            wait_clk(4);
        end
        gs_clk = 1'b0;
        wait_clk(4);
        gs_en_n = 1'b1;
        if (!hold_tail) wait_clk(12);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) exp_c[i] = 0;
        exp_ofs = 2;
        snap();
        chk(dcoc_req == 6'd0, "R1 requests idle", int'(dcoc_req), 0);
        check_all("R1 reset");
    endtask

    task automatic t_basic();
        snap();
        send_bits(7'b0111_010, 7, 1'b0);   // R4: coarse 7, fine 2
        expect_word(7, 2);
        check_all("R2 R4 word 7/2");
    endtask

    task automatic t_same();
        snap();
        send_bits(7'b0111_010, 7, 1'b0);
        check_all("R6 rewrite same word");
    endtask

    task automatic t_full();
        snap();
        send_bits(7'b1111_111, 7, 1'b0);
        expect_word(15, 7);
        check_all("R9 full scale");
    endtask

    task automatic t_partial();
        snap();
        send_bits(7'b0100_101, 7, 1'b0);
        expect_word(4, 5);
        check_all("R2 R3 coarse 4 fine 5");
    endtask

    task automatic t_zero();
        snap();
        send_bits(7'b0000_000, 7, 1'b0);
        expect_word(0, 0);
        check_all("R9 zero");
    endtask

    task automatic t_bad_len();
        snap();
        send_bits(6'b110_101, 6, 1'b0);
        check_all("R5 short frame");
        snap();
        send_bits(8'b1011_0110, 8, 1'b0);
        check_all("R5 long frame");
    endtask

    task automatic t_ofs();
        snap();
        ofs_val = 4'd5; ofs_load = 1'b1; wait_clk(1); ofs_load = 1'b0; wait_clk(3);
        exp_ofs = 5;
        check_all("R7 R8 offset load 5");
        snap();
        ofs_val = 4'd13; ofs_load = 1'b1; wait_clk(1); ofs_load = 1'b0; wait_clk(3);
        exp_ofs = 10;
        check_all("R7 offset clamp");
    endtask

    task automatic t_overlap();
        snap();
        ofs_val = 4'd7;
        send_bits(7'b1010_001, 7, 1'b1);
        ofs_load = 1'b1;   // window covers the commit inside the block
        wait_clk(1);
        ofs_load = 1'b1;
        wait_clk(12);
        ofs_load = 1'b0;
        wait_clk(4);
        expect_word(10, 1);
        exp_ofs = 7;
        check_all("R8 commit with offset load");
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            hi_cnt[i] = 0;
            rise_cnt[i] = 0;
        end
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_basic();
        t_same();
        t_full();
        t_partial();
        t_zero();
        t_bad_len();
        t_ofs();
        t_overlap();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule